// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests for a small processor core. Sources are four edge-sensitive pins, one wake-up input formed from a whole input port, nine on-chip peripheral event pulses and a software break strobe. There is also a pending reset entry that is raised whenever the block leaves reset. Each request is caught in a request bit. Maskable sources are gated by a per-source enable bit and by one global disable flag. The highest-priority eligible source drives the interrupt line, and its vector address appears on the vector output.

The core reads the vector and then pulses the acknowledge input for one cycle. At that clock edge the block clears the accepted request bit and sets the global disable flag. Software uses a four-entry write port to do three things: clear pending requests, load the enable bits, and choose the active edge of each pin. The same port loads the disable flag directly. Pin and port inputs are synchronized with two flops before edge detection.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Directly after reset, the reset entry (slot 0) is pending, so `irq` is 1 and `vec_addr` is 0xFFFC. All other requests are clear, all enables are 0, the disable flag is 1 and every edge select is 0.
- R2: A maskable slot drives `irq` only when its request bit is 1, its enable bit is 1 and the disable flag is 0. Writing `wr_sel`=3 loads the disable flag from `wr_data[0]`.
- R3: A write with `wr_sel`=0 keeps request bit i where `wr_data[i]`=1 and clears it where `wr_data[i]`=0. No write ever sets a request bit.
- R4: Slot 0 (reset) and slot 16 (break, from `brk_strobe`) raise `irq` whatever the enable bits and the disable flag hold.
- R5: Among eligible slots, the lowest slot number wins. Slot order: 0 reset, 1 serial-1 receive, 2 serial-1 transmit, 3 pin 0, 4 pin 1, 5 port wake-up, 6 pin 2, 7 pin 3, 8 to 14 the timer/serial-2/converter events, 15 reserved, 16 break.
- R6: `vec_addr` equals 0xFFFC minus twice the selected slot number; the high byte of each vector sits at `vec_addr`+1.
- R7: When `ack` is high in a cycle with `irq` high, the clock edge clears only the selected slot's request bit and sets the disable flag.
- R8: `edge_sel` bit p (written by `wr_sel`=2 from `wr_data[3:0]`, bit p for `ext_pin[p]`) selects a rising edge when 1 and a falling edge when 0. A pin change sets the request bit on the third rising clock edge after it.
- R9: The wake-up slot 5 is set by a falling edge of the AND of all `port_in` bits, with the same three-edge latency. Changes that leave the AND unchanged raise nothing.
- R10: With a pin held low, switching its edge select from 1 to 0 raises that pin's request. Switching it from 0 to 1 does not.
- R11: A request event in the same cycle as a clearing write or an acknowledge of that slot leaves the bit set.
- R12: Slot 15 is never requested.
- R13: Enable bits are written whole by `wr_sel`=1 (bit i for slot i), so a set enable can later be cleared.
- Peripheral map: `periph_evt[0]`→slot 1, `[1]`→2, `[k]`→slot k+6 for k=2..8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Edge-sensitive interrupt pins |
| port_in | input | PORT_W | Port levels for the wake-up AND |
| periph_evt | input | 9 | Single-cycle peripheral event pulses |
| brk_strobe | input | 1 | Software break event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 keep-mask, 1 enables, 2 edge selects, 3 disable flag |
| wr_data | input | 17 | Write data |
| ack | input | 1 | Single-cycle acknowledge from the core |
| irq | output | 1 | Interrupt request to the core |
| vec_addr | output | 16 | Low-byte vector address of the selected slot |

## Verification
Each peripheral event is pulsed alone. The request is then shown under the enable off and then on, which separates a wrong slot mapping, a missing enable gate and a wrong vector. All events plus break are fired together and drained one acknowledge at a time. This exposes priority-order errors and checks that break still appears while the flag blocks the rest. Each pin is driven through both edges under both edge selects, and the port AND is driven through rising, falling and masked toggles. Together these tell a polarity error from a latency error, and a real edge from the one that edge-select switching is expected to produce.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int SLOTS   = 17;
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int N_PIN   = 4;
  localparam int N_EVT   = 9;
  localparam int VEC_W   = 16;

  localparam int SLOT_RESET = 0;
  localparam int SLOT_KEY   = 5;
  localparam int SLOT_RSVD  = 15;
  localparam int SLOT_BRK   = 16;

  typedef logic [SLOTS-1:0] slot_vec_t;

  typedef enum logic [1:0] {
    REG_KEEP  = 2'd0,
    REG_EN    = 2'd1,
    REG_EDGE  = 2'd2,
    REG_FLAG  = 2'd3
  } reg_sel_e;

  localparam slot_vec_t UNMASKABLE =
    (slot_vec_t'(1) << SLOT_RESET) | (slot_vec_t'(1) << SLOT_BRK);

  function automatic int pin_slot(input int p);
    return (p < 2) ? 3 + p : 4 + p;
  endfunction

  function automatic int evt_slot(input int k);
    return (k < 2) ? k + 1 : k + 6;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] rise_sel,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] act_lvl;
  logic [WIDTH-1:0] prev_q;

  // Polarity-adjusted level: the active edge is always a rise here, so a
  // change of rise_sel alone can look like an edge.
  assign act_lvl = lvl ~^ rise_sel;
  assign evt     = act_lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= act_lvl;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    // R8: an event needs the adjusted level to have been inactive one cycle before
    assert_edge_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> !$past(act_lvl[i]));
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slot_vec_t        set_evt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  slot_vec_t        wr_data,
  input  logic             ack,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output slot_vec_t        req_q,
  output slot_vec_t        en_q,
  output logic [N_PIN-1:0] edge_q,
  output logic             flag_q
);
  slot_vec_t        req_nxt;
  slot_vec_t        en_nxt;
  logic [N_PIN-1:0] edge_nxt;
  logic             flag_nxt;
  logic             ack_take;

  assign ack_take = ack && ack_valid;

  always_comb begin
    req_nxt  = req_q;
    en_nxt   = en_q;
    edge_nxt = edge_q;
    flag_nxt = flag_q;
    if (wr_en && wr_sel == REG_KEEP) req_nxt = req_nxt & wr_data;
    if (wr_en && wr_sel == REG_EN)   en_nxt = wr_data;
    if (wr_en && wr_sel == REG_EDGE) edge_nxt = wr_data[N_PIN-1:0];
    if (wr_en && wr_sel == REG_FLAG) flag_nxt = wr_data[0];
    if (ack_take) begin
      req_nxt[ack_idx] = 1'b0;
      flag_nxt         = 1'b1;
    end
    req_nxt = req_nxt | set_evt;   // a new event outranks any clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= slot_vec_t'(1) << SLOT_RESET;
      en_q   <= '0;
      edge_q <= '0;
      flag_q <= 1'b1;
    end else begin
      req_q  <= req_nxt;
      en_q   <= en_nxt;
      edge_q <= edge_nxt;
      flag_q <= flag_nxt;
    end
  end

  // R7: accepted slot is cleared unless re-raised in the same cycle
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !set_evt[ack_idx]) |=> !req_q[$past(ack_idx)]);
  // R7: acceptance sets the disable flag
  assert_ack_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> flag_q);

  for (genvar i = 0; i < SLOTS; i++) begin : g_bit
    // R3: without an event a request bit can never rise
    assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !set_evt[i] |=> !$rose(req_q[i]));
    // R11: an event always leaves the bit set
    assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> req_q[i]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_vec_t        req,
  input  slot_vec_t        en,
  input  logic             flag,
  output logic             irq,
  output logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  slot_vec_t elig;

  assign elig = req & (UNMASKABLE | (en & {SLOTS{~flag}}));
  assign irq  = |elig;

  always_comb begin
    idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end

  assign vec = VEC_TOP - VEC_W'({idx, 1'b0});

  // R5: the pick is eligible and nothing of higher priority is
  assert_pick_highest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (req[idx] && (elig & ((slot_vec_t'(1) << idx) - slot_vec_t'(1))) == '0));
  // R2/R4: with the flag set only the unmaskable slots can be picked
  assert_flag_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && flag) |-> (idx == IDX_W'(SLOT_RESET) || idx == IDX_W'(SLOT_BRK)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int                PORT_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0]  VEC_TOP     = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PIN-1:0]  ext_pin,
  input  logic [PORT_W-1:0] port_in,
  input  logic [N_EVT-1:0]  periph_evt,
  input  logic              brk_strobe,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SLOTS-1:0]  wr_data,
  input  logic              ack,
  output logic              irq,
  output logic [VEC_W-1:0]  vec_addr
);
  localparam logic [VEC_W-1:0] VEC_LOW = VEC_TOP - VEC_W'(2 * (SLOTS - 1));

  logic [N_PIN-1:0]  pin_s;
  logic [N_PIN-1:0]  pin_evt;
  logic [PORT_W-1:0] port_s;
  logic              key_evt;
  slot_vec_t         set_evt;
  slot_vec_t         req_q;
  slot_vec_t         en_q;
  logic [N_PIN-1:0]  edge_q;
  logic              flag_q;
  logic [IDX_W-1:0]  pick_idx;

  irq_sync #(.WIDTH(N_PIN), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_pin), .dout(pin_s));

  irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .din(port_in), .dout(port_s));

  irq_edge_det #(.WIDTH(N_PIN)) u_pin_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pin_s), .rise_sel(edge_q), .evt(pin_evt));

  irq_edge_det #(.WIDTH(1)) u_key_edge (
    .clk(clk), .rst_n(rst_n), .lvl(&port_s), .rise_sel(1'b0), .evt(key_evt));

  always_comb begin
    set_evt           = '0;
    set_evt[SLOT_BRK] = brk_strobe;
    set_evt[SLOT_KEY] = key_evt;
    for (int k = 0; k < N_EVT; k++) set_evt[evt_slot(k)] = periph_evt[k];
    for (int p = 0; p < N_PIN; p++) set_evt[pin_slot(p)] = pin_evt[p];
  end

  irq_req_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack(ack), .ack_valid(irq), .ack_idx(pick_idx),
    .req_q(req_q), .en_q(en_q), .edge_q(edge_q), .flag_q(flag_q));

  irq_prio_pick #(.VEC_TOP(VEC_TOP)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req_q), .en(en_q), .flag(flag_q),
    .irq(irq), .idx(pick_idx), .vec(vec_addr));

  // R6: an offered vector is even and inside the table
  assert_vec_in_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!vec_addr[0] && vec_addr >= VEC_LOW && vec_addr <= VEC_TOP));
  // R12: the reserved slot never holds a request
  assert_rsvd_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q[SLOT_RSVD]);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ext_pin;
  logic [7:0]  port_in;
  logic [8:0]  periph_evt;
  logic        brk_strobe;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [16:0] wr_data;
  logic        ack;
  logic        irq;
  logic [15:0] vec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .periph_evt(periph_evt), .brk_strobe(brk_strobe), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ack(ack), .irq(irq), .vec_addr(vec_addr));

  function automatic logic [15:0] vec_of(input int s);
    return 16'hFFFC - 16'(2 * s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input bit exp_irq, input int slot);
    chk({tag, " irq"}, 32'(irq), 32'(exp_irq));
    if (exp_irq) chk({tag, " vec"}, 32'(vec_addr), 32'(vec_of(slot)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] s, input logic [16:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse(input logic [8:0] m, input logic b);
    @(negedge clk); periph_evt = m; brk_strobe = b;
    @(negedge clk); periph_evt = '0; brk_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; port_in = '0; periph_evt = '0; brk_strobe = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; ack = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset slot pending straight out of reset
    chk_irq("R1 reset entry", 1'b1, 0);
    do_ack;
    chk_irq("R7 reset entry acked", 1'b0, 0);

    // R1: disable flag set after reset blocks an enabled source
    reg_wr(2'd1, 17'h1FFFF);
    pulse(9'h001, 1'b0);
    chk_irq("R1 flag set blocks", 1'b0, 0);
    reg_wr(2'd3, 17'h0);
    chk_irq("R2 flag cleared", 1'b1, 1);
    reg_wr(2'd0, ~(17'(1) << 1));
    chk_irq("R3 keep-mask clear", 1'b0, 0);

    // R2/R6/R13: every peripheral event alone
    reg_wr(2'd1, 17'h0);
    for (int k = 0; k < 9; k++) begin
      int s;
      s = (k < 2) ? k + 1 : k + 6;
      pulse(9'(1) << k, 1'b0);
      chk_irq("R2 enable off", 1'b0, s);
      reg_wr(2'd1, 17'(1) << s);
      chk_irq("R6 single source vector", 1'b1, s);
      reg_wr(2'd1, ~(17'(1) << s));
      chk_irq("R13 enable cleared", 1'b0, s);
      reg_wr(2'd0, ~(17'(1) << s));
      reg_wr(2'd1, 17'h1FFFF);
      chk_irq("R3 request cleared", 1'b0, s);
      reg_wr(2'd1, 17'h0);
    end

    // R3/R12: writing all ones cannot set anything, reserved stays idle
    reg_wr(2'd1, 17'h1FFFF);
    reg_wr(2'd0, 17'h1FFFF);
    chk_irq("R3 R12 no software set", 1'b0, 0);

    // R5/R4: everything at once, drained by acknowledges
    begin
      logic [16:0] pend;
      pend = 17'h0;
      for (int k = 0; k < 9; k++) pend[(k < 2) ? k + 1 : k + 6] = 1'b1;
      pend[16] = 1'b1;
      pulse(9'h1FF, 1'b1);
      while (pend != 0) begin
        int lo;
        lo = 16;
        for (int i = 16; i >= 0; i--) if (pend[i]) lo = i;
        chk_irq("R5 priority order", 1'b1, lo);
        do_ack;
        pend[lo] = 1'b0;
        chk_irq("R4 break past flag", pend[16], 16);
        reg_wr(2'd3, 17'h0);
      end
      chk_irq("R5 drained", 1'b0, 0);
    end

    // R4: break with nothing enabled and flag set
    reg_wr(2'd1, 17'h0);
    reg_wr(2'd3, 17'h1);
    pulse(9'h0, 1'b1);
    chk_irq("R4 break unmaskable", 1'b1, 16);
    do_ack;
    chk_irq("R4 break acked", 1'b0, 16);
    reg_wr(2'd3, 17'h0);
    reg_wr(2'd1, 17'h1FFFF);

    // R11: event in the same cycle as a clearing write
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd0; wr_data = 17'h0; periph_evt = 9'h001;
    @(negedge clk); wr_en = 1'b0; periph_evt = '0;
    chk_irq("R11 event beats clear", 1'b1, 1);
    // R11: event in the same cycle as the acknowledge of that slot
    @(negedge clk); ack = 1'b1; periph_evt = 9'h001;
    @(negedge clk); ack = 1'b0; periph_evt = '0;
    reg_wr(2'd3, 17'h0);
    chk_irq("R11 event beats ack", 1'b1, 1);
    reg_wr(2'd0, 17'h0);

    // R7: only the selected slot is cleared
    pulse(9'h003, 1'b0);
    chk_irq("R7 first of two", 1'b1, 1);
    do_ack;
    chk_irq("R7 flag set by ack", 1'b0, 0);
    reg_wr(2'd3, 17'h0);
    chk_irq("R7 second remains", 1'b1, 2);
    reg_wr(2'd0, 17'h0);

    // R8: each pin, both edges, both selects
    for (int es = 0; es < 2; es++) begin
      reg_wr(2'd2, es ? 17'hF : 17'h0);
      idle(4);
      reg_wr(2'd0, 17'h0);
      for (int p = 0; p < 4; p++) begin
        int s;
        s = (p < 2) ? 3 + p : 4 + p;
        @(negedge clk); ext_pin[p] = 1'b1;
        if (p == 0 && es == 1) begin
          idle(2);
          chk_irq("R8 not before third edge", 1'b0, s);
          idle(1);
        end else begin
          idle(3);
        end
        chk_irq("R8 rising edge", es[0], s);
        reg_wr(2'd0, 17'h0);
        @(negedge clk); ext_pin[p] = 1'b0;
        idle(3);
        chk_irq("R8 falling edge", !es[0], s);
        reg_wr(2'd0, 17'h0);
      end
    end

    // R10: select switch with pins low
    idle(2);
    reg_wr(2'd0, 17'h0);
    chk_irq("R10 quiet before switch", 1'b0, 0);
    reg_wr(2'd2, 17'h0);
    idle(1);
    chk_irq("R10 switch to falling raises", 1'b1, 3);
    reg_wr(2'd0, 17'h0);
    reg_wr(2'd2, 17'hF);
    idle(2);
    chk_irq("R10 switch to rising quiet", 1'b0, 0);
    reg_wr(2'd2, 17'h0);
    idle(2);
    reg_wr(2'd0, 17'h0);

    // R9: port AND wake-up
    @(negedge clk); port_in = 8'hFF;
    idle(4);
    chk_irq("R9 AND rising quiet", 1'b0, 5);
    @(negedge clk); port_in[3] = 1'b0;
    idle(3);
    chk_irq("R9 AND falling", 1'b1, 5);
    reg_wr(2'd0, 17'h0);
    @(negedge clk); port_in[5] = 1'b0;
    idle(4);
    chk_irq("R9 AND already low", 1'b0, 5);
    @(negedge clk); port_in = 8'hFF;
    idle(4);
    @(negedge clk); port_in = 8'h00;
    idle(3);
    chk_irq("R9 all bits fall", 1'b1, 5);
    reg_wr(2'd0, 17'h0);
    chk_irq("R3 wake-up cleared", 1'b0, 5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule